// File: doc/BRIEF.md
# DMA Bus Turnaround Idle Inserter

This block sits inside an external bus controller and decides when the next bus cycle may begin after a DMA single-address transfer. The bus cycle generator reports each finished access with a completion strobe. A tag on the strobe says whether the device that answered with the DMA acknowledge drove the data bus. After such an acknowledged access, the block holds off the next access for a programmable number of idle cycles. This gives the data bus time to turn around between drivers.

A 3-bit code selects the idle length from a non-linear set of values. A mode bit chooses between two policies. In the first, the block idles only when a different driver takes the bus next. In the second, it idles after every acknowledged access, including back-to-back accesses to the same device. The idle length and the mode are captured on the completion strobe. A later change to the configuration therefore affects only accesses that complete afterwards.

The block also filters the refresh request and the external bus-mastership request while a DMA burst is running. A 2-bit priority field sets which of the two may pass during the burst. A request that is held back is remembered. It is forwarded once the burst ends.

Top module: `dma_turnaround_ctl`

## Requirements
- R1: The idle code maps 0..7 to 0, 1, 2, 4, 6, 8, 10 and 12 idle cycles. With the every-access mode bit set to 1, an acknowledged completion in cycle 0 holds `start_ok` low in cycles 1..N. `start_ok` rises in cycle N+1 if `nxt_req` is high.
- R2: A completion strobe with `acc_dack` = 0 clears any idle period in progress. A request in the following cycle is permitted at once.
- R3: With the mode bit 0, a pending idle period does not block a request with `nxt_dack` = 1 (the acknowledged device drives next).
- R4: With the mode bit 0, a request with `nxt_dack` = 0 is held for the full N idle cycles, as in R1.
- R5: With the mode bit 1, a request with `nxt_dack` = 1 is also held for the full N idle cycles.
- R6: `start_ok` is never high while `nxt_req` is low.
- R7: With priority code 00, both requests pass during a burst. A passed request appears on its output one cycle after it is seen.
- R8: With priority code 01, refresh passes during a burst and bus mastership is held back.
- R9: With priority code 10, and with the reserved code 11, both requests are held back during a burst.
- R10: A held-back request stays pending even if its input drops. It appears on its output in the cycle after the first clock edge that sees `burst_active` low.
- R11: Outside a burst, both requests pass one cycle later under every priority code.
- R12: Synchronous reset clears the idle counter and the pending requests. Both gated outputs go low, and a request right after reset is permitted.
- R13: A change to the idle code or the mode bit after a completion strobe does not alter the idle period already loaded, nor its policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idle_code | input | 3 | Idle length code (0,1,2,4,6,8,10,12 cycles) |
| cfg_every | input | 1 | 1: idle after every acknowledged access; 0: only on driver change |
| cfg_burst_prio | input | 2 | Request filter during DMA burst (00 both, 01 refresh only, 1x none) |
| acc_done | input | 1 | One-cycle strobe: a bus access finished |
| acc_dack | input | 1 | The finished access was driven by the acknowledged DMA device |
| nxt_req | input | 1 | The bus cycle generator wants to start an access |
| nxt_dack | input | 1 | The requested access is to the acknowledged DMA device |
| burst_active | input | 1 | A DMA burst transfer is in progress |
| refresh_req | input | 1 | Refresh request from the refresh engine |
| master_req | input | 1 | External bus-mastership request |
| start_ok | output | 1 | The requested access may begin this cycle |
| refresh_pass | output | 1 | Refresh request forwarded to the arbiter (registered) |
| master_pass | output | 1 | Mastership request forwarded to the arbiter (registered) |

## Verification
`start_ok` is formed in the same cycle from the registered idle count and the live request inputs. Each idle check therefore sets the request and samples after it settles, counting cycles from the completion strobe. The first sample falls one cycle after the strobe, and the permit is expected to rise exactly N+1 cycles after it. The gated requests pass through one register, so the bench drives the inputs on a falling edge and reads the outputs on the next falling edge. Pending release is read one edge after `burst_active` is dropped. The sweep covers every idle code under each mode and next-driver combination. It also covers every priority code, with and without a burst, for all four request patterns.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int CODE_W = 3;

  // Non-linear idle length: 0, 1, then steps of two up to twelve
  function automatic int unsigned idle_len(input logic [CODE_W-1:0] code);
    if (code == '0) return 0;
    if (code == 1) return 1;
    return 2 * (int'(code) - 1);
  endfunction

  localparam int unsigned MAX_IDLE = idle_len('1);
endpackage

// File: rtl/dtc_idle_counter.sv
module dtc_idle_counter
  import dtc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              every_in,
  input  logic              acc_done,
  input  logic              acc_dack,
  input  logic              nxt_req,
  input  logic              nxt_dack,
  output logic              start_ok
);
  logic [CNT_W-1:0] cnt_q;
  logic             every_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      every_q <= 1'b0;
    end else if (acc_done) begin
      cnt_q   <= acc_dack ? CNT_W'(idle_len(code)) : '0;
      every_q <= every_in;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign start_ok = nxt_req && ((cnt_q == '0) || (!every_q && nxt_dack));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_IDLE));
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !acc_done) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R2
  other_drv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_done && !acc_dack) |=> cnt_q == '0);
  // R6
  permit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> nxt_req);
endmodule

// File: rtl/dtc_req_gate.sv
module dtc_req_gate #(
  parameter int NREQ = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            burst,
  input  logic [NREQ-1:0] burst_allow,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] pass
);
  for (genvar i = 0; i < NREQ; i++) begin : g_chan
    logic pend_q;
    logic pass_q;
    logic want;
    logic allowed;

    assign want    = req[i] | pend_q;
    assign allowed = !burst || burst_allow[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
        pass_q <= 1'b0;
      end else begin
        pend_q <= want & !allowed;
        pass_q <= want & allowed;
      end
    end

    assign pass[i] = pass_q;

    // R10
    pass_source_chk: assert property (@(posedge clk) disable iff (rst)
      pass_q |-> $past(req[i] | pend_q));
    // R9
    held_chk: assert property (@(posedge clk) disable iff (rst)
      (burst && !burst_allow[i]) |=> !pass_q);
  end
endmodule

// File: rtl/dma_turnaround_ctl.sv
module dma_turnaround_ctl
  import dtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cfg_idle_code,
  input  logic              cfg_every,
  input  logic [1:0]        cfg_burst_prio,
  input  logic              acc_done,
  input  logic              acc_dack,
  input  logic              nxt_req,
  input  logic              nxt_dack,
  input  logic              burst_active,
  input  logic              refresh_req,
  input  logic              master_req,
  output logic              start_ok,
  output logic              refresh_pass,
  output logic              master_pass
);
  localparam int CNT_W = $clog2(MAX_IDLE + 1);
  localparam int NREQ  = 2;

  logic [NREQ-1:0] allow_v;
  logic [NREQ-1:0] req_v;
  logic [NREQ-1:0] pass_v;

  // Bit 0: refresh, bit 1: bus mastership. Reserved code 11 blocks both.
  assign allow_v[0] = !cfg_burst_prio[1];
  assign allow_v[1] = (cfg_burst_prio == 2'b00);
  assign req_v      = {master_req, refresh_req};

  dtc_idle_counter #(.CNT_W(CNT_W)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .code     (cfg_idle_code),
    .every_in (cfg_every),
    .acc_done (acc_done),
    .acc_dack (acc_dack),
    .nxt_req  (nxt_req),
    .nxt_dack (nxt_dack),
    .start_ok (start_ok)
  );

  dtc_req_gate #(.NREQ(NREQ)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .burst       (burst_active),
    .burst_allow (allow_v),
    .req         (req_v),
    .pass        (pass_v)
  );

  assign refresh_pass = pass_v[0];
  assign master_pass  = pass_v[1];

  // R8
  master_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_active && cfg_burst_prio != 2'b00) |=> !master_pass);
  // R9
  refresh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_active && cfg_burst_prio[1]) |=> !refresh_pass);
  // R11
  idle_bus_refresh_chk: assert property (@(posedge clk) disable iff (rst)
    (!burst_active && refresh_req) |=> refresh_pass);
  // R11
  idle_bus_master_chk: assert property (@(posedge clk) disable iff (rst)
    (!burst_active && master_req) |=> master_pass);
endmodule

// File: tb/test_dma_turnaround_ctl.sv
module test_dma_turnaround_ctl;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] cfg_idle_code;
  logic       cfg_every;
  logic [1:0] cfg_burst_prio;
  logic       acc_done, acc_dack, nxt_req, nxt_dack;
  logic       burst_active, refresh_req, master_req;
  logic       start_ok, refresh_pass, master_pass;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_turnaround_ctl i_dma_turnaround_ctl (
    .clk(clk), .rst(rst), .cfg_idle_code(cfg_idle_code), .cfg_every(cfg_every),
    .cfg_burst_prio(cfg_burst_prio), .acc_done(acc_done), .acc_dack(acc_dack),
    .nxt_req(nxt_req), .nxt_dack(nxt_dack), .burst_active(burst_active),
    .refresh_req(refresh_req), .master_req(master_req), .start_ok(start_ok),
    .refresh_pass(refresh_pass), .master_pass(master_pass)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input int c);
    return (c == 0) ? 0 : (c == 1) ? 1 : 2 * (c - 1);
  endfunction

  // Strobe in cycle 0, then a request from cycle 1 on; config is flipped after the strobe (R13)
  task automatic run_idle(input int code, input bit every, input bit ndack);
    int n;
    string tag;
    n = exp_len(code);
    if (every) tag = ndack ? "R5 R13" : "R1 R13";
    else       tag = ndack ? "R3 R13" : "R4 R13";
    @(negedge clk);
    cfg_idle_code = 3'(code); cfg_every = every;
    acc_done = 1'b1; acc_dack = 1'b1; nxt_req = 1'b0;
    @(negedge clk);
    acc_done = 1'b0; acc_dack = 1'b0;
    cfg_idle_code = 3'(~code); cfg_every = ~every;
    nxt_req = 1'b1; nxt_dack = ndack;
    for (int k = 1; k <= n + 1; k++) begin
      #1;
      check(tag, start_ok, (k > n) || (!every && ndack));
      @(negedge clk);
    end
    nxt_req = 1'b0;
  endtask

  task automatic run_gate(input int p, input bit b, input int r);
    logic er, em;
    string tag;
    if (!b)          tag = "R11";
    else if (p == 0) tag = "R7";
    else if (p == 1) tag = "R8";
    else             tag = "R9";
    @(negedge clk);
    burst_active = 1'b0; refresh_req = 1'b0; master_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cfg_burst_prio = 2'(p); burst_active = b;
    refresh_req = r[0]; master_req = r[1];
    er = r[0] && (!b || p < 2);
    em = r[1] && (!b || p == 0);
    @(negedge clk); #1;
    check(tag, refresh_pass, er);
    check(tag, master_pass, em);
    refresh_req = 1'b0; master_req = 1'b0;
    @(negedge clk); #1;
    check("R10", refresh_pass, 1'b0);
    check("R10", master_pass, 1'b0);
    burst_active = 1'b0;
    @(negedge clk); #1;
    check("R10", refresh_pass, r[0] && !er);
    check("R10", master_pass, r[1] && !em);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cfg_idle_code = '0; cfg_every = 1'b0; cfg_burst_prio = '0;
    acc_done = 1'b0; acc_dack = 1'b0; nxt_req = 1'b0; nxt_dack = 1'b0;
    burst_active = 1'b0; refresh_req = 1'b0; master_req = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; nxt_req = 1'b1;
    #1;
    check("R12", start_ok, 1'b1);
    check("R12", refresh_pass, 1'b0);
    check("R12", master_pass, 1'b0);
    nxt_req = 1'b0;
    #1;
    check("R6", start_ok, 1'b0);

    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 2; m++)
        for (int d = 0; d < 2; d++)
          run_idle(c, m[0], d[0]);

    // R2: a non-acknowledged completion cancels a loaded idle period
    @(negedge clk);
    cfg_idle_code = 3'd7; cfg_every = 1'b1; acc_done = 1'b1; acc_dack = 1'b1;
    @(negedge clk);
    acc_dack = 1'b0;
    @(negedge clk);
    acc_done = 1'b0; nxt_req = 1'b1; nxt_dack = 1'b0;
    #1;
    check("R2", start_ok, 1'b1);
    nxt_req = 1'b0;
    #1;
    check("R6", start_ok, 1'b0);

    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < 4; r++)
          run_gate(p, b[0], r);

    // R12: reset in the middle of an idle period and with requests pending
    @(negedge clk);
    cfg_idle_code = 3'd7; cfg_every = 1'b1; acc_done = 1'b1; acc_dack = 1'b1;
    @(negedge clk);
    acc_done = 1'b0; acc_dack = 1'b0;
    burst_active = 1'b1; cfg_burst_prio = 2'b10; refresh_req = 1'b1; master_req = 1'b1;
    @(negedge clk);
    rst = 1'b1; refresh_req = 1'b0; master_req = 1'b0;
    @(negedge clk);
    rst = 1'b0; burst_active = 1'b0;
    @(negedge clk);
    nxt_req = 1'b1; nxt_dack = 1'b0;
    #1;
    check("R12", start_ok, 1'b1);
    check("R12", refresh_pass, 1'b0);
    check("R12", master_pass, 1'b0);
    nxt_req = 1'b0;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule